// File: doc/BRIEF.md
# Speculative Retirement Buffer with Exception-PC Tracking

This block is the in-order retirement stage of a small speculative core. The front end places instructions at the tail in program order. Each instruction carries its PC, its new and previous physical destination registers, a branch flag and a flag that marks the first instruction of an asynchronous interrupt handler. Execution later reports each instruction as complete, and a branch reports its resolved target with that completion. Only the oldest entry can retire. Nothing the buffer holds becomes architecturally visible before it retires.

When a branch is found to be mispredicted, the branch's tag is presented on the squash port. Every younger entry is then marked cancelled in one cycle, including any handler instructions fetched down the wrong path. Cancelled entries still leave through the head, one per cycle. They do not commit, and their newly allocated physical register goes back to the free list.

The buffer maintains an architectural next-PC. When a handler-start entry commits, the next-PC is copied into the exception PC. Because of this, an interrupt taken on a wrong path can never leave a bad return address. A pulse on every handler-start commit lets the fetch side decrement its count of pending handlers.

Top module: `retire_buffer`

## Requirements
- R1: An allocation is accepted when `alloc_valid_i` is high and the buffer holds fewer than 16 entries. The entry's tag is the tail index shown on `alloc_tag_o` in that cycle. Tags advance by one per accepted allocation, modulo 16. When 16 entries are held, `alloc_ready_o` is low and an allocation request is ignored.
- R2: At most one entry leaves per cycle, and it is always the oldest. A non-cancelled head leaves only after it has completed, so a younger completed entry waits behind an incomplete head.
- R3: A commit raises `commit_valid_o` with the head's PC and raises `free_valid_o` with the entry's previous physical register, in the same cycle.
- R4: When a branch commits, the architectural next-PC takes the branch's resolved target on the following clock edge.
- R5: When a non-branch commits, the architectural next-PC takes the committed PC plus 4 on the following clock edge.
- R6: A squash marks every valid entry younger than the squash tag as cancelled. Age is the distance from the head modulo 16. The squashing branch itself, older entries, and an allocation accepted in the same cycle are not cancelled.
- R7: A cancelled head leaves whether or not it has completed. It raises `free_valid_o` with the entry's new physical register, keeps `commit_valid_o` low, and leaves the next-PC and exception PC unchanged.
- R8: When a handler-start entry commits, `handler_retired_o` pulses high for that cycle. On the following edge the exception PC takes the next-PC value held before that commit. The exception PC changes in no other way.
- R9: After reset the buffer is empty, `alloc_ready_o` is high, the next-PC equals `RESET_PC` (default 0x100), and the exception PC is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| alloc_valid_i | input | 1 | Allocation request |
| alloc_pc_i | input | 32 | PC of allocated instruction |
| alloc_new_preg_i | input | 6 | Newly allocated physical register |
| alloc_prev_preg_i | input | 6 | Previous mapping of the destination |
| alloc_is_branch_i | input | 1 | Entry is a branch |
| alloc_hstart_i | input | 1 | Entry is first instruction of an interrupt handler |
| alloc_ready_o | output | 1 | Buffer can accept an allocation |
| alloc_tag_o | output | 4 | Tag given to an allocation this cycle |
| done_valid_i | input | 1 | Completion report |
| done_tag_i | input | 4 | Tag of completed entry |
| done_target_i | input | 32 | Resolved target (used for branches) |
| squash_valid_i | input | 1 | Mispredict squash request |
| squash_tag_i | input | 4 | Tag of the mispredicted branch |
| commit_valid_o | output | 1 | Head commits this cycle |
| commit_pc_o | output | 32 | PC of the committing entry |
| free_valid_o | output | 1 | A physical register is released |
| free_preg_o | output | 6 | Released physical register |
| handler_retired_o | output | 1 | Handler-start entry committed |
| arch_npc_o | output | 32 | Architectural next-PC |
| arch_epc_o | output | 32 | Architectural exception PC |
| empty_o | output | 1 | Buffer holds no entries |

## Verification
Retirement outputs (`commit_valid_o`, `free_valid_o`, `handler_retired_o`) are decoded from registered entry state. They therefore appear in the cycle after the edge that completes or cancels the head, and they last one cycle per entry. The next-PC and exception PC move one edge after that retirement cycle. A scoreboard holds expected retirement events in program order. A monitor compares one event on every falling edge where a register is freed, so every result is sampled half a cycle after the edge that produced it. Architectural PCs are checked only after enough cycles for the whole queue to drain, plus one edge for their update.

// File: rtl/retire_pkg.sv
package retire_pkg;
  localparam int unsigned PC_W   = 32;
  localparam int unsigned PREG_W = 6;

  typedef struct packed {
    logic              valid;
    logic              done;
    logic              cancel;
    logic              is_branch;
    logic              hstart;
    logic [PC_W-1:0]   pc;
    logic [PC_W-1:0]   target;
    logic [PREG_W-1:0] new_preg;
    logic [PREG_W-1:0] prev_preg;
  } rb_entry_t;
endpackage

// File: rtl/retire_ptrs.sv
module retire_ptrs #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned TAG_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = TAG_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  output logic [TAG_W-1:0] head_o,
  output logic [TAG_W-1:0] tail_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [TAG_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) tail_q <= tail_q + 1'b1;
      if (pop_i)  head_q <= head_q + 1'b1;
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (!push_i && pop_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign head_o  = head_q;
  assign tail_o  = tail_q;
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);

  // R1
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !push_i);
  // R2
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !pop_i);
endmodule

// File: rtl/retire_arch.sv
module retire_arch #(
  parameter int unsigned PC_W = 32,
  parameter logic [PC_W-1:0] RESET_PC = 'h100
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            commit_i,
  input  logic            is_branch_i,
  input  logic            hstart_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic [PC_W-1:0] target_i,
  output logic [PC_W-1:0] npc_o,
  output logic [PC_W-1:0] epc_o
);
  logic [PC_W-1:0] npc_q, epc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      npc_q <= RESET_PC;
      epc_q <= '0;
    end else if (commit_i) begin
      npc_q <= is_branch_i ? target_i : pc_i + PC_W'(4);
      if (hstart_i) epc_q <= npc_q;
    end
  end

  assign npc_o = npc_q;
  assign epc_o = epc_q;

  // R8
  epc_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && hstart_i) |=> (epc_o == $past(npc_o)));
  // R7
  npc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> ($stable(npc_o) && $stable(epc_o)));
endmodule

// File: rtl/retire_buffer.sv
module retire_buffer
  import retire_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter logic [PC_W-1:0] RESET_PC = 'h100,
  localparam int unsigned TAG_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_valid_i,
  input  logic [PC_W-1:0]   alloc_pc_i,
  input  logic [PREG_W-1:0] alloc_new_preg_i,
  input  logic [PREG_W-1:0] alloc_prev_preg_i,
  input  logic              alloc_is_branch_i,
  input  logic              alloc_hstart_i,
  output logic              alloc_ready_o,
  output logic [TAG_W-1:0]  alloc_tag_o,
  input  logic              done_valid_i,
  input  logic [TAG_W-1:0]  done_tag_i,
  input  logic [PC_W-1:0]   done_target_i,
  input  logic              squash_valid_i,
  input  logic [TAG_W-1:0]  squash_tag_i,
  output logic              commit_valid_o,
  output logic [PC_W-1:0]   commit_pc_o,
  output logic              free_valid_o,
  output logic [PREG_W-1:0] free_preg_o,
  output logic              handler_retired_o,
  output logic [PC_W-1:0]   arch_npc_o,
  output logic [PC_W-1:0]   arch_epc_o,
  output logic              empty_o
);
  rb_entry_t        ent_q [DEPTH];
  rb_entry_t        head_e;
  logic [TAG_W-1:0] head_idx, tail_idx, squash_age;
  logic             full, empty, alloc_fire, retire, commit;

  retire_ptrs #(.DEPTH(DEPTH)) ptrs_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (alloc_fire),
    .pop_i  (retire),
    .head_o (head_idx),
    .tail_o (tail_idx),
    .full_o (full),
    .empty_o(empty)
  );

  assign alloc_fire = alloc_valid_i && !full;
  assign head_e     = ent_q[head_idx];
  assign retire     = !empty && (head_e.cancel || head_e.done);
  assign commit     = retire && !head_e.cancel;
  assign squash_age = squash_tag_i - head_idx;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [TAG_W-1:0] age;
    assign age = TAG_W'(i) - head_idx;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q[i] <= '0;
      end else if (alloc_fire && tail_idx == TAG_W'(i)) begin
        ent_q[i].valid     <= 1'b1;
        ent_q[i].done      <= 1'b0;
        ent_q[i].cancel    <= 1'b0;
        ent_q[i].is_branch <= alloc_is_branch_i;
        ent_q[i].hstart    <= alloc_hstart_i;
        ent_q[i].pc        <= alloc_pc_i;
        ent_q[i].target    <= '0;
        ent_q[i].new_preg  <= alloc_new_preg_i;
        ent_q[i].prev_preg <= alloc_prev_preg_i;
      end else begin
        if (retire && head_idx == TAG_W'(i)) ent_q[i].valid <= 1'b0;
        if (done_valid_i && done_tag_i == TAG_W'(i) && ent_q[i].valid) begin
          ent_q[i].done   <= 1'b1;
          ent_q[i].target <= done_target_i;
        end
        // younger than the mispredicted branch, relative to head
        if (squash_valid_i && ent_q[i].valid && age > squash_age)
          ent_q[i].cancel <= 1'b1;
      end
    end
  end

  retire_arch #(.PC_W(PC_W), .RESET_PC(RESET_PC)) arch_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .commit_i   (commit),
    .is_branch_i(head_e.is_branch),
    .hstart_i   (head_e.hstart),
    .pc_i       (head_e.pc),
    .target_i   (head_e.target),
    .npc_o      (arch_npc_o),
    .epc_o      (arch_epc_o)
  );

  assign alloc_ready_o     = !full;
  assign alloc_tag_o       = tail_idx;
  assign commit_valid_o    = commit;
  assign commit_pc_o       = head_e.pc;
  assign free_valid_o      = retire;
  assign free_preg_o       = head_e.cancel ? head_e.new_preg : head_e.prev_preg;
  assign handler_retired_o = commit && head_e.hstart;
  assign empty_o           = empty;

  // R3
  commit_frees_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_valid_o |-> free_valid_o);
  // R8
  handler_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    handler_retired_o |-> commit_valid_o);
  // R1
  ready_when_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> alloc_ready_o);
  // R2
  idle_when_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !free_valid_o);
endmodule

// File: tb/retire_buffer_tb.sv
module retire_buffer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_valid = 1'b0;
  logic [31:0] alloc_pc = '0;
  logic [5:0]  alloc_new = '0, alloc_prev = '0;
  logic        alloc_br = 1'b0, alloc_hs = 1'b0;
  logic        alloc_ready;
  logic [3:0]  alloc_tag;
  logic        done_valid = 1'b0;
  logic [3:0]  done_tag = '0;
  logic [31:0] done_target = '0;
  logic        squash_valid = 1'b0;
  logic [3:0]  squash_tag = '0;
  logic        commit_valid, free_valid, handler_retired, empty;
  logic [31:0] commit_pc, arch_npc, arch_epc;
  logic [5:0]  free_preg;

  int checks = 0, fails = 0, hpulses = 0;
  logic [38:0] exp_q [$];   // {cancel, pc, preg}
  logic [3:0]  tags [32];

  always #4 clk = ~clk;  // 125 MHz

  retire_buffer dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .alloc_valid_i(alloc_valid), .alloc_pc_i(alloc_pc),
    .alloc_new_preg_i(alloc_new), .alloc_prev_preg_i(alloc_prev),
    .alloc_is_branch_i(alloc_br), .alloc_hstart_i(alloc_hs),
    .alloc_ready_o(alloc_ready), .alloc_tag_o(alloc_tag),
    .done_valid_i(done_valid), .done_tag_i(done_tag), .done_target_i(done_target),
    .squash_valid_i(squash_valid), .squash_tag_i(squash_tag),
    .commit_valid_o(commit_valid), .commit_pc_o(commit_pc),
    .free_valid_o(free_valid), .free_preg_o(free_preg),
    .handler_retired_o(handler_retired),
    .arch_npc_o(arch_npc), .arch_epc_o(arch_epc), .empty_o(empty)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: one retirement event per cycle, compared in program order (R2, R3, R7)
  always @(negedge clk) begin
    if (rst_n && free_valid) begin
      logic [38:0] act, exp;
      act = {!commit_valid, commit_valid ? commit_pc : 32'h0, free_preg};
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2: actual %h expected no retirement", act);
      end else begin
        exp = exp_q.pop_front();
        check("R2/R3/R7 retire event", 64'(act), 64'(exp));
      end
    end
    if (rst_n && handler_retired) hpulses++;
  end

  task automatic alloc(input int idx, input logic [31:0] pc, input logic [5:0] nw,
                       input logic [5:0] pv, input logic br, input logic hs);
    @(negedge clk); #1;
    alloc_valid = 1'b1; alloc_pc = pc; alloc_new = nw; alloc_prev = pv;
    alloc_br = br; alloc_hs = hs;
    tags[idx] = alloc_tag;
    @(posedge clk); #1;
    alloc_valid = 1'b0;
  endtask

  task automatic complete(input logic [3:0] tag, input logic [31:0] tgt);
    @(negedge clk); #1;
    done_valid = 1'b1; done_tag = tag; done_target = tgt;
    @(posedge clk); #1;
    done_valid = 1'b0;
  endtask

  task automatic expect_commit(input logic [31:0] pc, input logic [5:0] pv);
    exp_q.push_back({1'b0, pc, pv});
  endtask

  task automatic expect_cancel(input logic [5:0] nw);
    exp_q.push_back({1'b1, 32'h0, nw});
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("R9 empty", 64'(empty), 64'd1);
    check("R9 ready", 64'(alloc_ready), 64'd1);
    check("R9 npc", 64'(arch_npc), 64'h100);
    check("R9 epc", 64'(arch_epc), 64'h0);

    // wrong-path handler: A, branch B, M0, I0(hstart), I1
    alloc(0, 32'h100, 6'd10, 6'd20, 1'b0, 1'b0);
    alloc(1, 32'h104, 6'd11, 6'd21, 1'b1, 1'b0);
    alloc(2, 32'h200, 6'd12, 6'd22, 1'b0, 1'b0);
    alloc(3, 32'h800, 6'd13, 6'd23, 1'b0, 1'b1);
    alloc(4, 32'h804, 6'd14, 6'd24, 1'b0, 1'b0);
    check("R1 tag order", 64'(tags[4]), 64'(tags[0] + 4'd4));
    // R6 squash younger than B; refetched I0' allocated in the same cycle survives
    @(negedge clk); #1;
    squash_valid = 1'b1; squash_tag = tags[1];
    alloc_valid = 1'b1; alloc_pc = 32'h800; alloc_new = 6'd15; alloc_prev = 6'd25;
    alloc_br = 1'b0; alloc_hs = 1'b1; tags[5] = alloc_tag;
    @(posedge clk); #1;
    squash_valid = 1'b0; alloc_valid = 1'b0;
    expect_commit(32'h100, 6'd20);
    expect_commit(32'h104, 6'd21);
    expect_cancel(6'd12);
    expect_cancel(6'd13);
    expect_cancel(6'd14);
    expect_commit(32'h800, 6'd25);

    complete(tags[2], 32'h0);  // younger completes first
    @(negedge clk);
    // R2 head incomplete: nothing retires
    check("R2 head blocks", 64'(free_valid), 64'd0);
    complete(tags[1], 32'h300);
    complete(tags[0], 32'h0);
    repeat (8) @(negedge clk);
    // R4 branch target, R7 cancelled drains leave PCs alone, R8 no premature EPC
    check("R4 npc after branch", 64'(arch_npc), 64'h300);
    check("R8 epc untouched", 64'(arch_epc), 64'h0);
    check("R8 no pulse yet", 64'(hpulses), 64'd0);
    complete(tags[5], 32'h0);
    repeat (3) @(negedge clk);
    check("R8 epc from npc", 64'(arch_epc), 64'h300);
    check("R5 npc after I0", 64'(arch_npc), 64'h804);
    check("R8 one pulse", 64'(hpulses), 64'd1);
    check("R6 queue drained", 64'(exp_q.size()), 64'd0);

    // fill to 16 across wrap, overflow request ignored
    check("R1 tag after wrap", 64'(alloc_tag), 64'd6);
    for (int k = 0; k < 16; k++) begin
      alloc(6 + k, 32'h1000 + 32'(4 * k), 6'(30 + k), 6'(k), 1'b0, 1'b0);
      expect_commit(32'h1000 + 32'(4 * k), 6'(k));
    end
    @(negedge clk);
    check("R1 full not ready", 64'(alloc_ready), 64'd0);
    alloc(30, 32'h2000, 6'd63, 6'd63, 1'b0, 1'b0);
    for (int k = 15; k >= 0; k--) complete(tags[6 + k], 32'h0);
    repeat (20) @(negedge clk);
    check("R1 overflow ignored", 64'(empty), 64'd1);
    check("R5 npc pc+4", 64'(arch_npc), 64'h1040);
    check("R8 epc held", 64'(arch_epc), 64'h300);
    check("R2 all retired", 64'(exp_q.size()), 64'd0);
    finish_run();
  end
endmodule